// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block is the decision core of a nested interrupt controller for 32 request lines. Each line has a latched pending flag, an enable flag and an 8-bit priority field of which only the two top bits are stored, which gives four effective urgency levels. Every cycle the block picks the most urgent pending and enabled line, with lower numbers being more urgent and ties going to the lowest line number. It compares that line against the priority of the handler that is running and raises an entry request to the processor when the candidate is strictly more urgent.

The processor side is modelled only as handshakes. An acknowledge pulse accepts the offered entry. It clears that line's pending flag and pushes its priority onto a four-deep stack of active levels. An exception-return pulse pops the stack. One cycle later the block reports either a tail-chain, when a waiting request beats the level that is now on top, or a plain restore.

A small register port writes and reads the priority, enable and pending fields of one line at a time.

Top module: `irq_prio_arb`

## Requirements
- R1: A pending flag is set on a rising edge of its request input. Holding the input high does not set the flag again. The flag is cleared when the processor acknowledges entry to that line.
- R2: The register port uses field code 0 for priority, 1 for enable (data bit 0) and 2 for pending (data bit 0; write 1 sets, write 0 clears). A priority write stores only data bits 7:6. A priority read returns the stored bits in 7:6 and zero in 5:0.
- R3: Among eligible lines, the one with the numerically lowest priority is offered on the entry node and entry priority outputs.
- R4: Among eligible lines of equal priority, the lowest line number is offered.
- R5: A pending line whose enable is 0 keeps its pending flag but is never offered.
- R6: With a handler active, entry is requested only for a candidate of strictly lower priority value than the top of the stack, and the nesting output is then high. An equal priority never preempts.
- R7: The active stack holds up to four levels. Each accepted acknowledge raises the depth output by one. No entry is requested while the stack is full.
- R8: A return with depth above zero lowers the depth by one. In the next cycle exactly one of tail-chain or restore pulses. Tail-chain pulses when an eligible line beats the level left on top, or when any eligible line exists and the stack is now empty.
- R9: A return at depth zero produces no pulse and leaves the depth unchanged. An acknowledge while no entry is requested changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 32 | Request lines, rising-edge sensitive |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_node_i | input | 5 | Line selected by the register port |
| cfg_field_i | input | 2 | Field code: 0 priority, 1 enable, 2 pending |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the selected field |
| ack_i | input | 1 | Processor accepts the offered entry |
| ret_i | input | 1 | Processor returns from the current handler |
| entry_req_o | output | 1 | Entry (or preemption) requested |
| entry_node_o | output | 5 | Offered line number |
| entry_prio_o | output | 2 | Priority level of the offered line |
| entry_nest_o | output | 1 | Offered entry would nest over an active handler |
| tail_chain_o | output | 1 | One-cycle pulse: return chains straight into a new handler |
| restore_o | output | 1 | One-cycle pulse: return restores the interrupted context |
| act_depth_o | output | 3 | Number of active handler levels |

## Verification
The hardest state to reach is a full active stack. It needs four handlers nested at four strictly decreasing levels, with a most-urgent request then waiting. The stimulus programs lines at levels 3, 2, 1 and 0 and accepts each one in turn. It then pends another level-0 line, which must not be offered, and returns once, which must tail-chain into it. The equal-priority restore case is reached by nesting a level-0 handler over a level-1 handler while a second level-1 line waits.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [1:0] {
      FLD_PRIO = 2'd0,
      FLD_EN   = 2'd1,
      FLD_PEND = 2'd2
   } fld_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
   import irq_arb_pkg::*;
#(
   parameter int N_LINES = 32,
   parameter int PRIO_W  = 2,
   parameter int FIELD_W = 8,
   localparam int NW     = $clog2(N_LINES)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [N_LINES-1:0]             req_i,
   input  logic                           cfg_we_i,
   input  logic [NW-1:0]                  cfg_node_i,
   input  logic [1:0]                     cfg_field_i,
   input  logic [FIELD_W-1:0]             cfg_wdata_i,
   input  logic                           clr_i,
   input  logic [NW-1:0]                  clr_node_i,
   output logic [N_LINES-1:0]             pend_o,
   output logic [N_LINES-1:0]             en_o,
   output logic [N_LINES-1:0][PRIO_W-1:0] prio_o
);
   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic req_q;
      logic sel;
      assign sel = cfg_we_i && (cfg_node_i == NW'(i));
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            req_q     <= 1'b0;
            pend_o[i] <= 1'b0;
            en_o[i]   <= 1'b0;
            prio_o[i] <= '0;
         end else begin
            req_q <= req_i[i];
            if (req_i[i] && !req_q)
               pend_o[i] <= 1'b1;
            else if (sel && fld_e'(cfg_field_i) == FLD_PEND)
               pend_o[i] <= cfg_wdata_i[0];
            else if (clr_i && clr_node_i == NW'(i))
               pend_o[i] <= 1'b0;
            if (sel && fld_e'(cfg_field_i) == FLD_EN)
               en_o[i] <= cfg_wdata_i[0];
            if (sel && fld_e'(cfg_field_i) == FLD_PRIO)
               prio_o[i] <= cfg_wdata_i[FIELD_W-1 -: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N_LINES = 32,
   parameter int PRIO_W  = 2,
   localparam int NW     = $clog2(N_LINES)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [N_LINES-1:0]             pend_i,
   input  logic [N_LINES-1:0]             en_i,
   input  logic [N_LINES-1:0][PRIO_W-1:0] prio_i,
   output logic                           win_v_o,
   output logic [NW-1:0]                  win_node_o,
   output logic [PRIO_W-1:0]              win_prio_o
);
   always_comb begin
      win_v_o    = 1'b0;
      win_node_o = '0;
      win_prio_o = '1;
      for (int i = 0; i < N_LINES; i++) begin
         if (pend_i[i] && en_i[i] && (!win_v_o || prio_i[i] < win_prio_o)) begin
            win_v_o    = 1'b1;
            win_node_o = NW'(i);
            win_prio_o = prio_i[i];
         end
      end
   end

   AST_WIN_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_v_o |-> (pend_i[win_node_o] && en_i[win_node_o])); // R5
endmodule

// File: rtl/irq_act_stack.sv
module irq_act_stack #(
   parameter int DEPTH  = 4,
   parameter int PRIO_W = 2,
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic              pop_i,
   output logic [DW-1:0]     depth_o,
   output logic [PRIO_W-1:0] top_o,
   output logic [PRIO_W-1:0] under_o
);
   logic [DEPTH-1:0][PRIO_W-1:0] stk_q;

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (!rst_ni)
            stk_q[k] <= '0;
         else if (push_i && depth_o == DW'(k))
            stk_q[k] <= push_prio_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         depth_o <= '0;
      else if (push_i && !pop_i)
         depth_o <= depth_o + 1'b1;
      else if (pop_i && !push_i)
         depth_o <= depth_o - 1'b1;
   end

   always_comb begin
      top_o   = '0;
      under_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (depth_o == DW'(k + 1)) top_o   = stk_q[k];
         if (depth_o == DW'(k + 2)) under_o = stk_q[k];
      end
   end

   AST_DEPTH_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      depth_o <= DW'(DEPTH)); // R7
   AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !pop_i) |=> depth_o == $past(depth_o) + 1'b1); // R7
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
   import irq_arb_pkg::*;
#(
   parameter int N_LINES     = 32,
   parameter int PRIO_W      = 2,
   parameter int FIELD_W     = 8,
   parameter int STACK_DEPTH = 4
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic [N_LINES-1:0]                   req_i,
   input  logic                                 cfg_we_i,
   input  logic [$clog2(N_LINES)-1:0]           cfg_node_i,
   input  logic [1:0]                           cfg_field_i,
   input  logic [FIELD_W-1:0]                   cfg_wdata_i,
   output logic [FIELD_W-1:0]                   cfg_rdata_o,
   input  logic                                 ack_i,
   input  logic                                 ret_i,
   output logic                                 entry_req_o,
   output logic [$clog2(N_LINES)-1:0]           entry_node_o,
   output logic [PRIO_W-1:0]                    entry_prio_o,
   output logic                                 entry_nest_o,
   output logic                                 tail_chain_o,
   output logic                                 restore_o,
   output logic [$clog2(STACK_DEPTH+1)-1:0]     act_depth_o
);
   localparam int NW = $clog2(N_LINES);
   localparam int DW = $clog2(STACK_DEPTH + 1);

   if (PRIO_W < 1 || PRIO_W > FIELD_W) begin : g_bad_prio
      $error("PRIO_W must lie in 1..FIELD_W");
   end
   if (N_LINES < 2 || STACK_DEPTH < 1) begin : g_bad_size
      $error("N_LINES must be at least 2 and STACK_DEPTH at least 1");
   end

   logic [N_LINES-1:0]             pend, en;
   logic [N_LINES-1:0][PRIO_W-1:0] prio;
   logic                           win_v;
   logic [NW-1:0]                  win_n;
   logic [PRIO_W-1:0]              win_p, top_p, under_p;
   logic                           push, pop, tail_d, tail_q, rest_q;

   assign push = ack_i && entry_req_o && !ret_i;
   assign pop  = ret_i && act_depth_o != '0;

   irq_pend_bank #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .FIELD_W(FIELD_W)) bank_i (
      .clk_i, .rst_ni, .req_i, .cfg_we_i, .cfg_node_i, .cfg_field_i, .cfg_wdata_i,
      .clr_i(push), .clr_node_i(win_n), .pend_o(pend), .en_o(en), .prio_o(prio));

   irq_pick #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) pick_i (
      .clk_i, .rst_ni, .pend_i(pend), .en_i(en), .prio_i(prio),
      .win_v_o(win_v), .win_node_o(win_n), .win_prio_o(win_p));

   irq_act_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) stack_i (
      .clk_i, .rst_ni, .push_i(push), .push_prio_i(win_p), .pop_i(pop),
      .depth_o(act_depth_o), .top_o(top_p), .under_o(under_p));

   assign entry_req_o  = win_v && act_depth_o != DW'(STACK_DEPTH) &&
                         (act_depth_o == '0 || win_p < top_p);
   assign entry_node_o = win_n;
   assign entry_prio_o = win_p;
   assign entry_nest_o = entry_req_o && act_depth_o != '0;

   assign tail_d = pop && win_v && (act_depth_o == DW'(1) || win_p < under_p);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tail_q <= 1'b0;
         rest_q <= 1'b0;
      end else begin
         tail_q <= tail_d;
         rest_q <= pop && !tail_d;
      end
   end
   assign tail_chain_o = tail_q;
   assign restore_o    = rest_q;

   always_comb begin
      cfg_rdata_o = '0;
      if (int'(cfg_node_i) < N_LINES) begin
         case (fld_e'(cfg_field_i))
            FLD_PRIO: cfg_rdata_o[FIELD_W-1 -: PRIO_W] = prio[cfg_node_i];
            FLD_EN:   cfg_rdata_o[0] = en[cfg_node_i];
            FLD_PEND: cfg_rdata_o[0] = pend[cfg_node_i];
            default:  cfg_rdata_o = '0;
         endcase
      end
   end

   AST_RET_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tail_chain_o && restore_o)); // R8
   AST_OUTCOME_NEEDS_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tail_chain_o || restore_o) |-> $past(ret_i)); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push && !cfg_we_i && !req_i[entry_node_o]) |=> !pend[$past(entry_node_o)]); // R1
endmodule

// File: tb/irq_prio_arb_tb_top.sv
module irq_prio_arb_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req = '0;
   logic        we = 1'b0;
   logic [4:0]  node = '0;
   logic [1:0]  field = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        ack = 1'b0, ret = 1'b0;
   logic        ereq, enest, tail, rest;
   logic [4:0]  enode;
   logic [1:0]  eprio;
   logic [2:0]  depth;

   int total = 0, bad = 0;
   int bprio [32];
   bit bpend [32];

   always #4 clk = ~clk;

   irq_prio_arb dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cfg_we_i(we), .cfg_node_i(node),
      .cfg_field_i(field), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .ack_i(ack),
      .ret_i(ret), .entry_req_o(ereq), .entry_node_o(enode), .entry_prio_o(eprio),
      .entry_nest_o(enest), .tail_chain_o(tail), .restore_o(rest), .act_depth_o(depth));

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(int f, int n, int d);
      @(negedge clk);
      we = 1'b1; field = 2'(f); node = 5'(n); wdata = 8'(d);
      @(negedge clk);
      we = 1'b0;
      #1;
   endtask

   task automatic rd(int f, int n, output int v);
      field = 2'(f); node = 5'(n);
      #1 v = int'(rdata);
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      #1;
   endtask

   task automatic do_ret();
      @(negedge clk); ret = 1'b1;
      @(negedge clk); ret = 1'b0;
      #1;
   endtask

   task automatic set_prio(int n, int d);
      cfg_wr(0, n, d);
      bprio[n] = (d >> 6) & 3;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v, exp_n, exp_p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset entry_req", int'(ereq), 0);
      check("R7 reset depth", int'(depth), 0);
      check("R8 reset pulses", int'(tail) + int'(rest), 0);

      // R2 priority field sweep
      for (int n = 0; n < 32; n++) begin
         set_prio(n, (n * 37 + 5) & 255);
         rd(0, n, v);
         check("R2 priority readback", v, ((n * 37 + 5) & 255) & 8'hC0);
         cfg_wr(1, n, 1);
      end
      rd(1, 9, v);
      check("R2 enable readback", v, 1);

      // R1 rising edge sets, level does not re-set
      @(negedge clk); req = '1;
      @(negedge clk); #1;
      rd(2, 0, v);  check("R1 pending after edge", v, 1);
      rd(2, 31, v); check("R1 pending after edge top", v, 1);
      cfg_wr(2, 3, 0);
      repeat (3) @(negedge clk);
      #1 rd(2, 3, v);
      check("R1 held level does not re-set", v, 0);
      @(negedge clk); req = '0;
      cfg_wr(2, 3, 1);
      for (int n = 0; n < 32; n++) bpend[n] = 1'b1;

      // R3 R4 winner sweep
      for (int it = 0; it < 32; it++) begin
         exp_n = -1; exp_p = 4;
         for (int n = 0; n < 32; n++)
            if (bpend[n] && bprio[n] < exp_p) begin exp_n = n; exp_p = bprio[n]; end
         check("R3 entry_req during sweep", int'(ereq), 1);
         check("R4 winner node", int'(enode), exp_n);
         check("R3 winner priority", int'(eprio), exp_p);
         cfg_wr(2, exp_n, 0);
         bpend[exp_n] = 1'b0;
      end
      check("R3 nothing pending", int'(ereq), 0);

      // R5 disabled line stays pending, does not compete
      set_prio(10, 8'h3F);
      set_prio(20, 8'h40);
      rd(0, 10, v); check("R2 low bits ignored", v, 0);
      cfg_wr(1, 10, 0);
      cfg_wr(2, 10, 1);
      cfg_wr(2, 20, 1);
      check("R5 disabled skipped", int'(enode), 20);
      rd(2, 10, v); check("R5 disabled still pending", v, 1);
      cfg_wr(1, 10, 1);
      check("R5 enabled competes", int'(enode), 10);

      // R6 R8 nesting, tail-chain, restore
      do_ack();
      check("R7 depth after ack", int'(depth), 1);
      rd(2, 10, v); check("R1 ack clears pending", v, 0);
      check("R6 lower level waits", int'(ereq), 0);
      do_ret();
      check("R8 tail-chain into waiting line", int'(tail), 1);
      check("R8 no restore on tail", int'(rest), 0);
      check("R8 depth after ret", int'(depth), 0);
      check("R8 chained node", int'(enode), 20);
      do_ack();
      set_prio(5, 8'h40);
      cfg_wr(2, 5, 1);
      check("R6 equal priority no preempt", int'(ereq), 0);
      set_prio(7, 8'h00);
      cfg_wr(2, 7, 1);
      check("R6 preempt requested", int'(ereq), 1);
      check("R6 nest flag", int'(enest), 1);
      check("R6 preempt node", int'(enode), 7);
      do_ack();
      check("R7 nested depth", int'(depth), 2);
      do_ret();
      check("R8 restore on equal level", int'(rest), 1);
      check("R8 no tail on equal level", int'(tail), 0);
      do_ret();
      check("R8 tail when stack empties", int'(tail), 1);
      do_ack();
      check("R6 entry without nest", int'(depth), 1);
      do_ret();
      check("R8 restore when idle", int'(rest), 1);
      check("R8 depth zero", int'(depth), 0);

      // R7 full stack
      set_prio(30, 8'hC0);
      set_prio(25, 8'h80);
      cfg_wr(2, 30, 1); do_ack();
      cfg_wr(2, 25, 1); do_ack();
      cfg_wr(2, 5, 1);  do_ack();
      cfg_wr(2, 7, 1);  do_ack();
      check("R7 depth full", int'(depth), 4);
      cfg_wr(2, 10, 1);
      check("R7 no entry when full", int'(ereq), 0);
      do_ret();
      check("R8 tail from full", int'(tail), 1);
      check("R8 depth three", int'(depth), 3);
      check("R6 nest over level one", int'(enest), 1);
      do_ack();
      check("R7 refilled", int'(depth), 4);
      for (int k = 3; k >= 0; k--) begin
         do_ret();
         check("R8 restore unwinding", int'(rest), 1);
         check("R8 depth unwinding", int'(depth), k);
      end

      // R9 ignored handshakes
      do_ret();
      check("R9 ret at depth zero no pulse", int'(tail) + int'(rest), 0);
      check("R9 ret at depth zero depth", int'(depth), 0);
      do_ack();
      check("R9 ack without request", int'(depth), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule